// File: doc/BRIEF.md
# Read-Sequence Save/Restore Command Detector

This block sits beside the access logic of a memory wrapper and watches the address bus during selected read cycles. When it sees a fixed run of six read addresses, it asks the nonvolatile controller to copy the SRAM into the nonvolatile array (save) or to copy the nonvolatile array back into the SRAM (restore). The two keys share their first five addresses and differ only in the sixth. A single step tracker therefore follows both keys and chooses between save and restore on the last step.

One access is presented per clock, qualified by `cyc_stb`. On the sixth, completing cycle of a valid key, `dq_hiz` goes high in that same cycle so that the wrapper floats its data bus. On the next clock edge a one-cycle `save_go` or `restore_go` pulse is issued. While the controller raises `nv_busy`, the detector ignores the bus.

Top module: `nv_seq_detect`

## Requirements
- R1: The read addresses 0E38, 31C7, 03E0, 3C1F, 303F, 0FC0 (hex, bits 13..0) on six consecutive selected cycles raise `save_go` for exactly one clock, starting at the clock edge that ends the sixth cycle. `restore_go` stays low.
- R2: The run 0E38, 31C7, 03E0, 3C1F, 303F, 0C63 raises `restore_go` for exactly one clock at the same point. `save_go` stays low.
- R3: Only address bits 13..0 are compared. The value of bit 14 never affects recognition.
- R4: A selected cycle with `we_n` low anywhere in the run cancels it. The tracker returns to idle, and the key must be started again from its first address.
- R5: The level of `oe_n` has no effect on recognition.
- R6: During the first five cycles of a key, and during any cycle that does not complete a key, `dq_hiz` is low. During the completing sixth cycle, `dq_hiz` is high combinationally, before the clock edge.
- R7: A selected read whose address is not the expected one returns the tracker to idle. If that address is 0E38, the tracker instead counts it as the first step of a new key.
- R8: Cycles with `ce_n` high, and clocks with `cyc_stb` low, neither advance nor reset the tracker.
- R9: While `nv_busy` is high, cycles are ignored: no step is taken, no pulse fires, and `dq_hiz` stays low. After a pulse the tracker is idle, and a sixth address alone does not fire again.
- R10: After reset, `save_go`, `restore_go` and `dq_hiz` are low and the tracker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | One access is presented in this clock |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low (not used for detection) |
| addr | input | 15 | Access address |
| nv_busy | input | 1 | Nonvolatile controller is busy |
| save_go | output | 1 | One-cycle request to start a save |
| restore_go | output | 1 | One-cycle request to start a restore |
| dq_hiz | output | 1 | Float the data bus on the completing cycle |

## Verification
The hardest cases to reach from the ports are the tracker's partial states: a run that has reached step five and is then interrupted by a deselected cycle, a write, or a busy period. The effect shows only in whether a later sixth address fires. The bench builds each such prefix explicitly and then presents the remaining key addresses, so that a lost or a falsely advanced step shows up as a missing or an extra pulse. The restart-on-0E38 path is reached by breaking a run with the first key address itself, and then finishing from there.

// File: rtl/nv_seq_detect.sv
module nv_seq_detect #(
  parameter int ADDR_W = 15,
  parameter int KEY_W = 14,
  parameter logic [KEY_W-1:0] KEY0 = 14'h0E38,
  parameter logic [KEY_W-1:0] KEY1 = 14'h31C7,
  parameter logic [KEY_W-1:0] KEY2 = 14'h03E0,
  parameter logic [KEY_W-1:0] KEY3 = 14'h3C1F,
  parameter logic [KEY_W-1:0] KEY4 = 14'h303F,
  parameter logic [KEY_W-1:0] KEY_SAVE = 14'h0FC0,
  parameter logic [KEY_W-1:0] KEY_REST = 14'h0C63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              nv_busy,
  output logic              save_go,
  output logic              restore_go,
  output logic              dq_hiz
);
  localparam int LAST = 5;
  localparam int SW = $clog2(LAST + 1);

  logic [SW-1:0]    step;
  logic [KEY_W-1:0] key;
  logic             sel, rd, hit_save, hit_rest;
  logic             oe_unused;

  function automatic logic [KEY_W-1:0] key_at(input logic [SW-1:0] s);
    case (s)
      SW'(0):  return KEY0;
      SW'(1):  return KEY1;
      SW'(2):  return KEY2;
      SW'(3):  return KEY3;
      default: return KEY4;
    endcase
  endfunction

  assign oe_unused = oe_n;
  assign key      = addr[KEY_W-1:0];
  assign sel      = cyc_stb && !ce_n && !nv_busy;
  assign rd       = sel && we_n;
  assign hit_save = rd && step == SW'(LAST) && key == KEY_SAVE;
  assign hit_rest = rd && step == SW'(LAST) && key == KEY_REST;
  assign dq_hiz   = hit_save || hit_rest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= '0;
      save_go    <= 1'b0;
      restore_go <= 1'b0;
    end else begin
      save_go    <= hit_save;
      restore_go <= hit_rest;
      if (sel) begin
        if (!we_n)
          step <= '0;
        else if (step != SW'(LAST) && key == key_at(step))
          step <= step + SW'(1);
        else if (dq_hiz)
          step <= '0;
        else if (key == KEY0)
          step <= SW'(1);
        else
          step <= '0;
      end
    end
  end

  p_one_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_go && restore_go));
  p_save_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    save_go |=> !save_go);
  p_rest_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restore_go |=> !restore_go);
  p_hiz_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hiz |=> (save_go || restore_go));
  p_write_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !ce_n && !we_n && !nv_busy) |=> step == '0);
  p_desel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_stb || ce_n) |=> $stable(step));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> $stable(step));
  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (save_go || restore_go) |-> step == '0);
  p_step_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step <= SW'(LAST));
endmodule

// File: tb/nv_seq_detect_test.sv
module nv_seq_detect_test;
  logic clk = 0, rst_n = 0, cyc_stb = 0, ce_n = 1, we_n = 1, oe_n = 0, nv_busy = 0;
  logic [14:0] addr = '0;
  logic save_go, restore_go, dq_hiz;
  logic s_hiz, s_save, s_rest;
  int errs = 0, checks = 0;

  localparam logic [14:0] K0 = 15'h0E38, K1 = 15'h31C7, K2 = 15'h03E0,
                          K3 = 15'h3C1F, K4 = 15'h303F, KS = 15'h0FC0, KR = 15'h0C63;

  always #10 clk = ~clk;

  nv_seq_detect uut (.clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ce_n(ce_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .nv_busy(nv_busy),
    .save_go(save_go), .restore_go(restore_go), .dq_hiz(dq_hiz));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic stb, input logic c, input logic w, input logic o,
                     input logic b, input logic [14:0] a);
    @(negedge clk);
    cyc_stb = stb; ce_n = c; we_n = w; oe_n = o; nv_busy = b; addr = a;
    #5 s_hiz = dq_hiz;
    @(posedge clk);
    #1 s_save = save_go; s_rest = restore_go;
  endtask

  task automatic rd(input logic [14:0] a);
    cyc(1, 0, 1, 0, 0, a);
  endtask

  task automatic flush();
    rd(15'h0000);
    rd(15'h0000);
  endtask

  task automatic expect_none(input string req);
    check({req, " hiz"}, s_hiz, 0);
    check({req, " save"}, s_save, 0);
    check({req, " restore"}, s_rest, 0);
  endtask

  task automatic prefix(input logic [14:0] hi);
    rd(K0 | hi); rd(K1 | hi); rd(K2 | hi); rd(K3 | hi); rd(K4 | hi);
  endtask

  task automatic t_reset();
    #1;
    check("R10 save", save_go, 0);
    check("R10 restore", restore_go, 0);
    check("R10 hiz", dq_hiz, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_save();
    rd(K0); expect_none("R6 step1");
    rd(K1); expect_none("R6 step2");
    rd(K2); rd(K3); rd(K4); expect_none("R6 step5");
    rd(KS);
    check("R6 hiz sixth", s_hiz, 1);
    check("R1 save", s_save, 1);
    check("R1 no restore", s_rest, 0);
    rd(15'h0000); check("R1 single pulse", s_save, 0);
  endtask

  task automatic t_restore();
    flush(); prefix(0); rd(KR);
    check("R2 hiz", s_hiz, 1);
    check("R2 restore", s_rest, 1);
    check("R2 no save", s_save, 0);
    rd(15'h0000); check("R2 single pulse", s_rest, 0);
  endtask

  task automatic t_bit14();
    flush(); prefix(15'h4000); rd(KS | 15'h4000);
    check("R3 save with bit14", s_save, 1);
  endtask

  task automatic t_write();
    flush(); rd(K0); rd(K1); rd(K2);
    cyc(1, 0, 0, 0, 0, K3);
    rd(K3); rd(K4); rd(KS);
    expect_none("R4 write cancels");
    flush(); prefix(0); cyc(1, 0, 0, 0, 0, KS);
    expect_none("R4 write sixth");
  endtask

  task automatic t_oe();
    flush();
    cyc(1, 0, 1, 1, 0, K0); cyc(1, 0, 1, 1, 0, K1); cyc(1, 0, 1, 0, 0, K2);
    cyc(1, 0, 1, 1, 0, K3); cyc(1, 0, 1, 1, 0, K4); cyc(1, 0, 1, 1, 0, KR);
    check("R5 restore with oe high", s_rest, 1);
  endtask

  task automatic t_mismatch();
    flush(); rd(K0); rd(K1); rd(K2); rd(15'h1234);
    rd(K3); rd(K4); rd(KS);
    expect_none("R7 mismatch idle");
    flush(); prefix(0); rd(15'h0001);
    expect_none("R7 bad sixth");
    flush(); rd(K0); rd(K1); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(KS);
    check("R7 restart on first key", s_save, 1);
  endtask

  task automatic t_desel();
    flush(); rd(K0); rd(K1);
    cyc(1, 1, 1, 0, 0, 15'h1111);
    cyc(1, 1, 0, 0, 0, 15'h2222);
    cyc(0, 0, 0, 0, 0, 15'h3333);
    rd(K2); rd(K3); rd(K4);
    cyc(1, 1, 1, 0, 0, KS);
    check("R8 deselected sixth no hiz", s_hiz, 0);
    rd(KS);
    check("R8 save after deselects", s_save, 1);
  endtask

  task automatic t_busy();
    flush(); prefix(0);
    cyc(1, 0, 1, 0, 1, KS);
    expect_none("R9 busy sixth");
    cyc(1, 0, 0, 0, 1, 15'h0000);
    rd(KS);
    check("R9 state kept over busy", s_save, 1);
    rd(KS);
    check("R9 idle after pulse", s_save, 0);
    flush();
    cyc(1, 0, 1, 0, 1, K0); cyc(1, 0, 1, 0, 1, K1); cyc(1, 0, 1, 0, 1, K2);
    cyc(1, 0, 1, 0, 1, K3); cyc(1, 0, 1, 0, 1, K4); cyc(1, 0, 1, 0, 1, KR);
    expect_none("R9 busy whole key");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_save(); t_restore(); t_bit14(); t_write();
        t_oe(); t_mismatch(); t_desel(); t_busy();
      end
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule